// File: doc/BRIEF.md
# Retimed Lookup Cell

This block is one logic cell of a pipelined reconfigurable array. Every cycle it evaluates a programmed 32-entry truth table. Four of the table's index bits come from routed inputs. The fifth comes straight from an adjacent cell's output, without passing through the routing fabric. The whole array shares one fixed clock and its interconnect is pipelined, so signals reach the cell with different latencies. To equalise them, each routed input first passes through its own register bank. A per-input tap select picks how many clock cycles of delay to add, from none up to seven.

A mode bit turns the cell into two 4-input functions that share the four delayed inputs. One function reads the lower half of the table and the other reads the upper half. Configuration is loaded through a parallel write port that is qualified by a strobe. The data pins have no valid or ready signals, because the array advances on every cycle and has no back-pressure. A new value is taken on each route input at every rising edge.

Top module: `lutcell_retimed`

## Requirements
- R1: While `rst_n` is low, the stored table, the tap selects and the mode bit are all zero. Both outputs therefore read 0 during reset and in the cycle that follows it.
- R2: On a rising edge where `cfg_we` is high, the cell captures `cfg_table`, `cfg_taps` and `cfg_split`, and they govern the outputs from that edge on. When `cfg_we` is low, the configuration bus has no effect.
- R3: The tap select for route input i is `cfg_taps[3*i+2:3*i]`. A value k from 1 to 7 makes the table see `route_in[i]` as it was sampled k rising edges earlier. A value of 0 passes `route_in[i]` through combinationally in the same cycle.
- R4: Reset clears every bank register. After reset, a delay tap of k reads 0 until k rising edges of post-reset input have been shifted in, whatever `route_in` held during reset.
- R5: When `cfg_split` = 0, the table index is {`nbr_in`, d3, d2, d1, d0}, where di is delayed input i and `nbr_in` is the most significant bit. `f_out0` is the table bit at that index and `f_out1` is 0.
- R6: When `cfg_split` = 1, `f_out0` is table bit {0,d3..d0} and `f_out1` is table bit {1,d3..d0}. `nbr_in` has no effect in this mode.
- R7: The banks shift on every cycle whatever the configuration is. A new tap select therefore reads history that is already stored, starting in the cycle after it is written.
- R8: `nbr_in` is never delayed. A change on it reaches `f_out0` in wide mode within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_table | input | 32 | Truth table; bit n is the output for index n |
| cfg_taps | input | 12 | Four 3-bit delay selects; input i uses bits 3i+2..3i |
| cfg_split | input | 1 | 0 = one 5-input function, 1 = two 4-input functions |
| route_in | input | 4 | Routed inputs from the pipelined network |
| nbr_in | input | 1 | Direct input from the adjacent cell (fifth index bit) |
| f_out0 | output | 1 | Table output 0 |
| f_out1 | output | 1 | Table output 1 (split mode only, else 0) |

## Verification
A corrupted bank register appears at the outputs only while a tap selects it and the table separates the two values of that input. A stuck or misaligned shift stage therefore shows up exactly k cycles after the input change that it should carry. The bench programs tables that depend on one input alone so that such errors cannot be masked. A wrong stored table bit or a wrong mode bit is visible in the same cycle in which an index reaches it. Random input patterns under several tap mixes make every index and every tap depth occur.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  // Defaults shared by the cell and its bench.
  localparam int unsigned ROUTED_DEF = 4;
  localparam int unsigned TAPS_DEF   = 8;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } lut_mode_e;
endpackage

// File: rtl/retime_bank.sv
module retime_bank #(
  parameter int unsigned TAPS  = 8,
  parameter int unsigned TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d,
  input  logic [TAP_W-1:0] tap,
  output logic             q
);
  localparam int unsigned NREG = TAPS - 1;

  logic [NREG-1:0] stage;
  logic [TAPS-1:0] tap_vec;

  for (genvar j = 0; j < NREG; j++) begin : g_stage
    if (j == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[j] <= 1'b0;
        else        stage[j] <= stage[j-1];
      end
    end
  end

  // Tap 0 is the live input; tap k is k cycles old.
  assign tap_vec = {stage, d};

  always_comb begin
    if (int'(tap) < TAPS) q = tap_vec[tap];
    else                  q = stage[NREG-1];
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned LUT_W  = 32,
  parameter int unsigned TAPS_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [LUT_W-1:0]      tbl_in,
  input  logic [TAPS_W-1:0]     taps_in,
  input  logic                  split_in,
  output logic [LUT_W-1:0]      tbl_q,
  output logic [TAPS_W-1:0]     taps_q,
  output lutcell_pkg::lut_mode_e mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      taps_q <= '0;
      mode_q <= lutcell_pkg::MODE_WIDE;
    end else if (we) begin
      tbl_q  <= tbl_in;
      taps_q <= taps_in;
      mode_q <= split_in ? lutcell_pkg::MODE_SPLIT : lutcell_pkg::MODE_WIDE;
    end
  end
endmodule

// File: rtl/lut_core.sv
module lut_core #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned LUT_W = 2 ** (N_IN + 1)
) (
  input  logic [LUT_W-1:0]       tbl,
  input  logic [N_IN-1:0]        idx,
  input  logic                   nbr,
  input  lutcell_pkg::lut_mode_e mode,
  output logic                   out0,
  output logic                   out1
);
  always_comb begin
    if (mode == lutcell_pkg::MODE_SPLIT) begin
      out0 = tbl[{1'b0, idx}];
      out1 = tbl[{1'b1, idx}];
    end else begin
      out0 = tbl[{nbr, idx}];
      out1 = 1'b0;
    end
  end
endmodule

// File: rtl/lutcell_retimed.sv
module lutcell_retimed #(
  parameter int unsigned N_IN = lutcell_pkg::ROUTED_DEF,
  parameter int unsigned TAPS = lutcell_pkg::TAPS_DEF,
  localparam int unsigned TAP_W = $clog2(TAPS),
  localparam int unsigned LUT_W = 2 ** (N_IN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [LUT_W-1:0]       cfg_table,
  input  logic [N_IN*TAP_W-1:0]  cfg_taps,
  input  logic                   cfg_split,
  input  logic [N_IN-1:0]        route_in,
  input  logic                   nbr_in,
  output logic                   f_out0,
  output logic                   f_out1
);
  logic [LUT_W-1:0]       tbl_q;
  logic [N_IN*TAP_W-1:0]  tap_q;
  lutcell_pkg::lut_mode_e mode_q;
  logic [N_IN-1:0]        dly;

  cfg_store #(.LUT_W(LUT_W), .TAPS_W(N_IN*TAP_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .tbl_in  (cfg_table),
    .taps_in (cfg_taps),
    .split_in(cfg_split),
    .tbl_q   (tbl_q),
    .taps_q  (tap_q),
    .mode_q  (mode_q)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_bank
    retime_bank #(.TAPS(TAPS), .TAP_W(TAP_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (route_in[i]),
      .tap  (tap_q[i*TAP_W +: TAP_W]),
      .q    (dly[i])
    );
  end

  lut_core #(.N_IN(N_IN), .LUT_W(LUT_W)) u_core (
    .tbl (tbl_q),
    .idx (dly),
    .nbr (nbr_in),
    .mode(mode_q),
    .out0(f_out0),
    .out1(f_out1)
  );
endmodule

// File: rtl/lutcell_retimed_chk.sv
module lutcell_retimed_chk #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned TAP_W = 3,
  parameter int unsigned LUT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [LUT_W-1:0]      cfg_table,
  input logic [N_IN*TAP_W-1:0] cfg_taps,
  input logic                  cfg_split,
  input logic [N_IN-1:0]       route_in,
  input logic                  f_out1,
  input logic [LUT_W-1:0]      tbl_q,
  input logic [N_IN*TAP_W-1:0] tap_q,
  input logic                  mode_q,
  input logic [N_IN-1:0]       dly
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (tbl_q == '0 && tap_q == '0 && !mode_q));

  p_cfg_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (tbl_q == $past(cfg_table) && tap_q == $past(cfg_taps)
                && mode_q == $past(cfg_split)));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && age != 2'd0) |=> ($stable(tbl_q) && $stable(tap_q) && $stable(mode_q)));

  p_wide_out1_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !f_out1);

  p_split_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (f_out1 == tbl_q[{1'b1, dly}]));

  for (genvar i = 0; i < N_IN; i++) begin : g_tap
    p_tap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && tap_q[i*TAP_W +: TAP_W] == 1 && $past(tap_q[i*TAP_W +: TAP_W]) == 1)
      |-> (dly[i] == $past(route_in[i])));
  end
endmodule

bind lutcell_retimed lutcell_retimed_chk #(
  .N_IN (N_IN),
  .TAP_W(TAP_W),
  .LUT_W(LUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_table(cfg_table),
  .cfg_taps (cfg_taps),
  .cfg_split(cfg_split),
  .route_in (route_in),
  .f_out1   (f_out1),
  .tbl_q    (tbl_q),
  .tap_q    (tap_q),
  .mode_q   (mode_q),
  .dly      (dly)
);

// File: tb/lutcell_retimed_test.sv
`timescale 1ns/1ps
module lutcell_retimed_test;
  localparam int NI = 4;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_table = '0;
  logic [11:0] cfg_taps = '0;
  logic        cfg_split = 1'b0;
  logic [3:0]  route_in = '0;
  logic        nbr_in = 1'b0;
  logic        f_out0, f_out1;

  always #2 clk = ~clk;

  lutcell_retimed uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_table(cfg_table),
    .cfg_taps(cfg_taps), .cfg_split(cfg_split), .route_in(route_in),
    .nbr_in(nbr_in), .f_out0(f_out0), .f_out1(f_out1)
  );

  // Behavioural reference: configuration copy and input history queue.
  logic [31:0] m_tbl = '0;
  logic [11:0] m_taps = '0;
  logic        m_split = 1'b0;
  logic [3:0]  hist[$];
  int compared = 0;
  int mismatched = 0;

  initial begin
    for (int k = 0; k < NT - 1; k++) hist.push_back(4'h0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tbl = '0; m_taps = '0; m_split = 1'b0;
      hist.delete();
      for (int k = 0; k < NT - 1; k++) hist.push_back(4'h0);
    end else begin
      if (cfg_we) begin
        m_tbl = cfg_table; m_taps = cfg_taps; m_split = cfg_split;
      end
      hist.push_front(route_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [3:0] exp_dly();
    logic [3:0] d;
    for (int i = 0; i < NI; i++) begin
      int k = int'(m_taps[3*i +: 3]);
      d[i] = (k == 0) ? route_in[i] : hist[k-1][i];
    end
    return d;
  endfunction

  task automatic check(input string tag);
    logic [3:0] d = exp_dly();
    logic e0, e1;
    if (m_split) begin
      e0 = m_tbl[{1'b0, d}]; e1 = m_tbl[{1'b1, d}];
    end else begin
      e0 = m_tbl[{nbr_in, d}]; e1 = 1'b0;
    end
    compared += 2;
    if (f_out0 !== e0) begin
      mismatched++;
      $display("FAIL %s f_out0 actual=%0b expected=%0b t=%0t", tag, f_out0, e0, $time);
    end
    if (f_out1 !== e1) begin
      mismatched++;
      $display("FAIL %s f_out1 actual=%0b expected=%0b t=%0t", tag, f_out1, e1, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check(tag);
  endtask

  task automatic write_cfg(input logic [31:0] t, input logic [11:0] tp,
                           input logic sp, input string tag);
    cfg_table = t; cfg_taps = tp; cfg_split = sp; cfg_we = 1'b1;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic run_rand(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      tick(tag);
      route_in = 4'($urandom);
      nbr_in = 1'($urandom);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, with non-zero inputs present.
    route_in = 4'hF; nbr_in = 1'b1;
    repeat (2) @(posedge clk);
    repeat (3) tick("R1");
    rst_n = 1'b1;
    tick("R1");
    // R4: table follows input 0 alone; every tap at 7; banks start cleared.
    write_cfg(32'hAAAA_AAAA, {4{3'd7}}, 1'b0, "R4");
    repeat (10) tick("R4");
    // R3: single-input step on input 0 at tap 3.
    write_cfg(32'hAAAA_AAAA, 12'o0003, 1'b0, "R3");
    route_in = 4'h0;
    repeat (8) tick("R3");
    route_in = 4'h1; tick("R3"); route_in = 4'h0;
    repeat (6) tick("R3");
    // R3: mixed taps, random data.
    write_cfg(32'h8E3C_71A5, {3'd1, 3'd5, 3'd0, 3'd3}, 1'b0, "R3");
    run_rand(40, "R3");
    // R5: wide mode, mixed function.
    write_cfg(32'h6996_1EE1, {4{3'd2}}, 1'b0, "R5");
    run_rand(30, "R5");
    // R2: configuration bus moves without a strobe.
    for (int c = 0; c < 10; c++) begin
      cfg_table = $urandom; cfg_taps = 12'($urandom); cfg_split = 1'($urandom);
      tick("R2");
      route_in = 4'($urandom); nbr_in = 1'($urandom);
    end
    // R6: split mode, neighbour input toggling.
    write_cfg(32'hA5C3_0FF0, {3'd4, 3'd0, 3'd5, 3'd7}, 1'b1, "R6");
    run_rand(40, "R6");
    // R7: tap rewrites while data keeps flowing.
    for (int r = 0; r < 5; r++) begin
      write_cfg(32'hFE01_7C83, 12'($urandom), 1'($urandom), "R7");
      run_rand(5, "R7");
    end
    // R8: neighbour bit only, index from deep taps.
    write_cfg(32'hFFFF_0000, {4{3'd6}}, 1'b0, "R8");
    for (int c = 0; c < 20; c++) begin
      tick("R8");
      nbr_in = ~nbr_in;
      route_in = 4'($urandom);
    end
    summary();
    $finish;
  end
endmodule